// File: doc/BRIEF.md
# Per-Block Background Brightness Flag Generator

This block watches the background pixels that lie under an overlay region and decides, for each of up to 32 blocks laid out in a single row or a single column, whether the background there is bright. The blocks are laid out along one axis, starting at coordinate 0 of the region. Each block has its own width along that axis. It spans the full extent of the other axis, from 0 to a configured last index. A block's width is either one shared fixed value or a per-block value from a 16-entry lookup table. Both are held in a compact code whose real width in pixels is (code + 1) × 2.

For every block, the block sums the luma of the pixels inside it. When the block's final pixel arrives in raster order, it compares the average luma (the floor of sum divided by pixel count) against an 8-bit threshold. It then writes the resulting bright flag into a 64-bit flag vector at a configurable rotating position. The vector is exposed as two 32-bit words. A later recolouring stage receives a per-pixel flag. That flag comes either from the previous frame's flags, supplied as an input, or from the flags computed so far in the current frame.

Top module: `luma_flag_gen`

## Requirements
- R1: With `vertical`=0 the blocks follow the x coordinate and y is the spanning coordinate. With `vertical`=1 the blocks follow y and x is the spanning coordinate. The spanning coordinate runs from 0 to `spanLast`.
- R2: With `widthMode`=0 every block is (`fixCode`+1)×2 pixels wide. The blocks are contiguous from axis position 0, in block order.
- R3: With `widthMode`=1, block i takes its code from lookup entry (`lutIdx`+i) mod 16, and its width is (code+1)×2. Entry k sits at bits [6k+5:6k] of `lutCodes`.
- R4: There are `blkCountM1`+1 blocks. A pixel whose axis position is past the end of the last block is ignored: it adds nothing to any sum and produces no pixel flag.
- R5: A block's flag becomes 1 exactly when floor(sum of its lumas / its pixel count) is greater than `threshold`, and 0 otherwise. It is written in the cycle after the block's last pixel. The last pixel is the one at axis position equal to the block's end and spanning position equal to `spanLast`.
- R6: Block i's flag is stored at bit (`flagsIndex`+i) mod 64 of the flag vector. Bits 31..0 appear on `curFlagsLo` and bits 63..32 on `curFlagsHi`.
- R7: After reset, and in the cycle after a `frameStart` pulse, all flags, sums and `frameDone` are 0. A pixel presented together with `frameStart` is ignored.
- R8: `frameDone` is high for one cycle, in the cycle after the last block (index `blkCountM1`) is evaluated.
- R9: When `modeSel` bit 0 (statistics) is 0, no sums accumulate, the flags stay 0 and `frameDone` stays low.
- R10: When `modeSel` bit 1 (overlap) is 1, each in-range valid pixel gives `pixFlagValid`=1 in the next cycle. `pixFlag` is then the bit of that pixel's block position, taken from the current flags as they stood before the pixel (`flagSel`=1) or from {`lastFlagsHi`,`lastFlagsLo`} (`flagSel`=0). Otherwise both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Clears the flags and sums for a new frame |
| pixValid | input | 1 | Background pixel present |
| pixX | input | 12 | Pixel x within the region |
| pixY | input | 12 | Pixel y within the region |
| pixLuma | input | 8 | Pixel luma |
| modeSel | input | 2 | Bit 0 statistics enable, bit 1 overlap enable |
| vertical | input | 1 | 0 blocks along x, 1 blocks along y |
| widthMode | input | 1 | 0 fixed width, 1 lookup widths |
| fixCode | input | 6 | Fixed width code, width = (code+1)×2 |
| blkCountM1 | input | 5 | Number of blocks minus one |
| lutIdx | input | 4 | Lookup entry of block 0 |
| lutCodes | input | 96 | 16 width codes of 6 bits |
| spanLast | input | 12 | Last index of the spanning coordinate |
| threshold | input | 8 | Brightness threshold |
| flagsIndex | input | 6 | Flag bit position of block 0 |
| flagSel | input | 1 | Pixel flag source: 0 previous frame, 1 live |
| lastFlagsLo | input | 32 | Previous frame flags, bits 31..0 |
| lastFlagsHi | input | 32 | Previous frame flags, bits 63..32 |
| curFlagsLo | output | 32 | Current flags, bits 31..0 |
| curFlagsHi | output | 32 | Current flags, bits 63..32 |
| pixFlagValid | output | 1 | Pixel flag valid |
| pixFlag | output | 1 | Flag for the previous cycle's pixel |
| frameDone | output | 1 | Last block evaluated |

## Verification
A wrong block boundary or a stale sum shows up as a wrong bit in `curFlagsLo`/`curFlagsHi`. It appears one cycle after the affected block's last pixel, and the bench catches it there because it compares against its model on every clock. A wrong block index or flag position also shows up earlier, on `pixFlag` during the frame when the overlap mode is on. Frames exercise the threshold edge, lookup index wrap, flag position wrap, the maximum block count, statistics off and a clear that collides with a pixel.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  // Per-pixel strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // frame start
    logic accEn;     // add pixel into its block sum
    logic evalEn;    // pixel closes its block
    logic lastBlk;   // closed block is the final one
    logic pixOut;    // emit a per-pixel flag
  } lfgStrobe_t;
endpackage

// File: rtl/lfg_ctrl.sv
module lfg_ctrl
  import lfg_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int MAX_BLOCKS = 32,
  parameter int CODE_W     = 6,
  parameter int LUT_DEPTH  = 16,
  localparam int CNT_W  = $clog2(MAX_BLOCKS),
  localparam int LUT_IW = $clog2(LUT_DEPTH),
  localparam int BW_W   = CODE_W + 2,
  localparam int END_W  = BW_W + CNT_W,
  localparam int PCNT_W = BW_W + COORD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameStart,
  input  logic                        pixValid,
  input  logic [COORD_W-1:0]          pixX,
  input  logic [COORD_W-1:0]          pixY,
  input  logic [1:0]                  modeSel,
  input  logic                        vertical,
  input  logic                        widthMode,
  input  logic [CODE_W-1:0]           fixCode,
  input  logic [CNT_W-1:0]            blkCountM1,
  input  logic [LUT_IW-1:0]           lutIdx,
  input  logic [LUT_DEPTH*CODE_W-1:0] lutCodes,
  input  logic [COORD_W-1:0]          spanLast,
  output lfgStrobe_t                  strobe,
  output logic [CNT_W-1:0]            blkIdx,
  output logic [PCNT_W-1:0]           pixCnt
);
  logic [BW_W-1:0]  blkWidth [MAX_BLOCKS];
  logic [END_W-1:0] cum      [MAX_BLOCKS+1];

  assign cum[0] = '0;

  // Width of every block and running boundary positions
  for (genvar g = 0; g < MAX_BLOCKS; g++) begin : g_blk
    logic [LUT_IW-1:0] lutSel;
    logic [CODE_W-1:0] code;
    assign lutSel      = lutIdx + LUT_IW'(g);
    assign code        = widthMode ? lutCodes[lutSel*CODE_W +: CODE_W] : fixCode;
    assign blkWidth[g] = {({1'b0, code} + {{CODE_W{1'b0}}, 1'b1}), 1'b0};
    assign cum[g+1]    = cum[g] + END_W'(blkWidth[g]);
  end

  logic [END_W-1:0]   axisPos;
  logic [COORD_W-1:0] otherPos;
  logic [CNT_W:0]     hitCnt;
  logic               inRange;
  logic               lastPix;

  always_comb begin
    axisPos  = END_W'(vertical ? pixY : pixX);
    otherPos = vertical ? pixX : pixY;
    hitCnt   = '0;
    for (int i = 0; i < MAX_BLOCKS; i++) begin
      if (cum[i+1] <= axisPos) hitCnt = hitCnt + 1'b1;
    end
    inRange = hitCnt <= {1'b0, blkCountM1};
    blkIdx  = hitCnt[CNT_W-1:0];
    lastPix = ((axisPos + 1'b1) == cum[{1'b0, blkIdx} + 1'b1]) && (otherPos == spanLast);
    pixCnt  = PCNT_W'(blkWidth[blkIdx]) * PCNT_W'(spanLast) + PCNT_W'(blkWidth[blkIdx]);
  end

  always_comb begin
    strobe.clearAll = frameStart;
    strobe.accEn    = !frameStart && pixValid && inRange && modeSel[0];
    strobe.evalEn   = strobe.accEn && lastPix;
    strobe.lastBlk  = strobe.evalEn && (blkIdx == blkCountM1);
    strobe.pixOut   = !frameStart && pixValid && inRange && modeSel[1];
  end

  // R4: an accumulated pixel always lies before the end of the last block
  p_no_past_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accEn |-> (axisPos < cum[{1'b0, blkCountM1} + 1'b1]));

endmodule

// File: rtl/lfg_datapath.sv
module lfg_datapath
  import lfg_pkg::*;
#(
  parameter int LUMA_W     = 8,
  parameter int MAX_BLOCKS = 32,
  parameter int FLAG_W     = 64,
  parameter int PCNT_W     = 20,
  localparam int CNT_W  = $clog2(MAX_BLOCKS),
  localparam int IDX_W  = $clog2(FLAG_W),
  localparam int SUM_W  = LUMA_W + PCNT_W,
  localparam int PROD_W = LUMA_W + 1 + PCNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfgStrobe_t        strobe,
  input  logic [CNT_W-1:0]  blkIdx,
  input  logic [PCNT_W-1:0] pixCnt,
  input  logic [LUMA_W-1:0] pixLuma,
  input  logic [LUMA_W-1:0] threshold,
  input  logic [IDX_W-1:0]  flagsIndex,
  input  logic              flagSel,
  input  logic [FLAG_W-1:0] lastFlags,
  output logic [FLAG_W-1:0] curFlags,
  output logic              pixFlagValid,
  output logic              pixFlag,
  output logic              frameDone
);
  logic [SUM_W-1:0]  accArr [MAX_BLOCKS];
  logic [SUM_W-1:0]  accNext;
  logic [PROD_W-1:0] limit;
  logic [IDX_W-1:0]  bitPos;
  logic              bright;

  assign accNext = accArr[blkIdx] + SUM_W'(pixLuma);
  // floor(sum/cnt) > thr  <=>  sum >= (thr+1)*cnt
  assign limit   = PROD_W'({1'b0, threshold} + 1'b1) * PROD_W'(pixCnt);
  assign bright  = PROD_W'(accNext) >= limit;
  assign bitPos  = flagsIndex + IDX_W'(blkIdx);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      for (int i = 0; i < MAX_BLOCKS; i++) accArr[i] <= '0;
      curFlags     <= '0;
      frameDone    <= 1'b0;
      pixFlagValid <= 1'b0;
      pixFlag      <= 1'b0;
    end else begin
      frameDone    <= strobe.lastBlk;
      pixFlagValid <= strobe.pixOut;
      pixFlag      <= strobe.pixOut && (flagSel ? curFlags[bitPos] : lastFlags[bitPos]);
      if (strobe.accEn) accArr[blkIdx] <= accNext;
      if (strobe.evalEn) curFlags[bitPos] <= bright;
    end
  end

  // R7: a frame start leaves an empty flag vector
  p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clearAll) |-> (curFlags == '0));
  // R5: flags move only when a block closes
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.evalEn) && !$past(strobe.clearAll)) |-> $stable(curFlags));
  // R6: one closing block touches at most one flag bit
  p_single_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.clearAll) |-> ($countones(curFlags ^ $past(curFlags)) <= 1));

endmodule

// File: rtl/luma_flag_gen.sv
module luma_flag_gen
  import lfg_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int LUMA_W     = 8,
  parameter int MAX_BLOCKS = 32,
  parameter int FLAG_W     = 64,
  parameter int CODE_W     = 6,
  parameter int LUT_DEPTH  = 16,
  localparam int CNT_W  = $clog2(MAX_BLOCKS),
  localparam int IDX_W  = $clog2(FLAG_W),
  localparam int LUT_IW = $clog2(LUT_DEPTH),
  localparam int HALF_W = FLAG_W / 2,
  localparam int PCNT_W = CODE_W + 2 + COORD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameStart,
  input  logic                        pixValid,
  input  logic [COORD_W-1:0]          pixX,
  input  logic [COORD_W-1:0]          pixY,
  input  logic [LUMA_W-1:0]           pixLuma,
  input  logic [1:0]                  modeSel,
  input  logic                        vertical,
  input  logic                        widthMode,
  input  logic [CODE_W-1:0]           fixCode,
  input  logic [CNT_W-1:0]            blkCountM1,
  input  logic [LUT_IW-1:0]           lutIdx,
  input  logic [LUT_DEPTH*CODE_W-1:0] lutCodes,
  input  logic [COORD_W-1:0]          spanLast,
  input  logic [LUMA_W-1:0]           threshold,
  input  logic [IDX_W-1:0]            flagsIndex,
  input  logic                        flagSel,
  input  logic [HALF_W-1:0]           lastFlagsLo,
  input  logic [HALF_W-1:0]           lastFlagsHi,
  output logic [HALF_W-1:0]           curFlagsLo,
  output logic [HALF_W-1:0]           curFlagsHi,
  output logic                        pixFlagValid,
  output logic                        pixFlag,
  output logic                        frameDone
);
  lfgStrobe_t        strobe;
  logic [CNT_W-1:0]  blkIdx;
  logic [PCNT_W-1:0] pixCnt;
  logic [FLAG_W-1:0] curFlags;

  lfg_ctrl #(
    .COORD_W(COORD_W), .MAX_BLOCKS(MAX_BLOCKS), .CODE_W(CODE_W), .LUT_DEPTH(LUT_DEPTH)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .modeSel(modeSel), .vertical(vertical),
    .widthMode(widthMode), .fixCode(fixCode), .blkCountM1(blkCountM1),
    .lutIdx(lutIdx), .lutCodes(lutCodes), .spanLast(spanLast),
    .strobe(strobe), .blkIdx(blkIdx), .pixCnt(pixCnt)
  );

  lfg_datapath #(
    .LUMA_W(LUMA_W), .MAX_BLOCKS(MAX_BLOCKS), .FLAG_W(FLAG_W), .PCNT_W(PCNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blkIdx(blkIdx), .pixCnt(pixCnt),
    .pixLuma(pixLuma), .threshold(threshold), .flagsIndex(flagsIndex),
    .flagSel(flagSel), .lastFlags({lastFlagsHi, lastFlagsLo}),
    .curFlags(curFlags), .pixFlagValid(pixFlagValid), .pixFlag(pixFlag),
    .frameDone(frameDone)
  );

  assign curFlagsLo = curFlags[HALF_W-1:0];
  assign curFlagsHi = curFlags[FLAG_W-1:HALF_W];

  // R10: a pixel flag only follows a valid pixel with overlap enabled
  p_pix_flag_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixFlagValid |-> ($past(pixValid) && $past(modeSel[1]) && !$past(frameStart)));
  // R8: completion needs statistics on and a pixel in the previous cycle
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(pixValid) && $past(modeSel[0])));
  // R9: with statistics off the flags cannot change
  p_stats_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(modeSel[0]) && !$past(frameStart)) |-> $stable({curFlagsHi, curFlagsLo}));

endmodule

// File: tb/luma_flag_gen_tb_top.sv
module luma_flag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        frameStart, pixValid;
  logic [11:0] pixX, pixY, spanLast;
  logic [7:0]  pixLuma, threshold;
  logic [1:0]  modeSel;
  logic        vertical, widthMode, flagSel;
  logic [5:0]  fixCode, flagsIndex;
  logic [4:0]  blkCountM1;
  logic [3:0]  lutIdx;
  logic [95:0] lutCodes;
  logic [31:0] lastFlagsLo, lastFlagsHi;
  logic [31:0] curFlagsLo, curFlagsHi;
  logic        pixFlagValid, pixFlag, frameDone;

  int nCmp = 0;
  int nBad = 0;
  bit modelOn = 0;
  bit ended = 0;
  int doneSeen = 0;

  always #4 clk = ~clk;  // 125 MHz

  luma_flag_gen dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .pixLuma(pixLuma), .modeSel(modeSel),
    .vertical(vertical), .widthMode(widthMode), .fixCode(fixCode),
    .blkCountM1(blkCountM1), .lutIdx(lutIdx), .lutCodes(lutCodes),
    .spanLast(spanLast), .threshold(threshold), .flagsIndex(flagsIndex),
    .flagSel(flagSel), .lastFlagsLo(lastFlagsLo), .lastFlagsHi(lastFlagsHi),
    .curFlagsLo(curFlagsLo), .curFlagsHi(curFlagsHi),
    .pixFlagValid(pixFlagValid), .pixFlag(pixFlag), .frameDone(frameDone)
  );

  // Behavioural reference model
  int          mAcc[32];
  logic [63:0] mCur;
  bit          mDone, mPv, mPf;

  always @(posedge clk) begin
    if (!rstN || frameStart) begin
      foreach (mAcc[i]) mAcc[i] = 0;
      mCur = '0; mDone = 0; mPv = 0; mPf = 0;
    end else begin
      int a, o, b, start, w, endp, bw, bitp, code;
      mDone = 0; mPv = 0; mPf = 0;
      if (pixValid) begin
        a = vertical ? int'(pixY) : int'(pixX);
        o = vertical ? int'(pixX) : int'(pixY);
        b = -1; start = 0; endp = 0; bw = 0;
        for (int i = 0; i <= int'(blkCountM1); i++) begin
          code = widthMode ? int'(lutCodes[((int'(lutIdx) + i) % 16) * 6 +: 6]) : int'(fixCode);
          w = (code + 1) * 2;
          if (b < 0 && a >= start && a < start + w) begin
            b = i; endp = start + w - 1; bw = w;
          end
          start = start + w;
        end
        if (b >= 0) begin
          bitp = (int'(flagsIndex) + b) % 64;
          if (modeSel[1]) begin
            mPv = 1;
            mPf = flagSel ? mCur[bitp] : ((bitp < 32) ? lastFlagsLo[bitp] : lastFlagsHi[bitp-32]);
          end
          if (modeSel[0]) begin
            mAcc[b] = mAcc[b] + int'(pixLuma);
            if (a == endp && o == int'(spanLast)) begin
              mCur[bitp] = (mAcc[b] / (bw * (int'(spanLast) + 1))) > int'(threshold);
              if (b == int'(blkCountM1)) mDone = 1;
            end
          end
        end
      end
    end
  end

  task automatic checkEq(string tag, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (modelOn && !ended) begin
      checkEq("R5/R6 flags vs model", {curFlagsHi, curFlagsLo}, mCur);
      checkEq("R8 done vs model", 64'(frameDone), 64'(mDone));
      checkEq("R10 pixFlagValid vs model", 64'(pixFlagValid), 64'(mPv));
      checkEq("R10 pixFlag vs model", 64'(pixFlag), 64'(mPf));
      if (frameDone) doneSeen++;
    end
  end

  function automatic logic [7:0] lumaOf(int fid, int a, int o);
    case (fid)
      0: return (a < 4) ? 8'd200 : (a < 8) ? 8'd50 : (a < 12) ? 8'd101 : 8'd100;
      1: return (a < 2) ? (((a + o) % 2) ? 8'd255 : 8'd0) : (a < 8) ? 8'd126 : 8'd255;
      default: return ((a / 2) % 2 == 0) ? 8'd180 : 8'd20;
    endcase
  endfunction

  task automatic runFrame(int fid, int totalLen);
    int rows, cols;
    frameStart = 1; @(negedge clk); frameStart = 0;
    rows = vertical ? totalLen : int'(spanLast) + 1;
    cols = vertical ? int'(spanLast) + 1 : totalLen;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        pixValid = 1; pixX = 12'(c); pixY = 12'(r);
        pixLuma = lumaOf(fid, vertical ? r : c, vertical ? c : r);
        @(negedge clk);
      end
    end
    pixValid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [63:0] expD;
    rstN = 0; frameStart = 0; pixValid = 0; pixX = 0; pixY = 0; pixLuma = 0;
    modeSel = 2'b11; vertical = 0; widthMode = 0; fixCode = 6'd1; blkCountM1 = 5'd3;
    lutIdx = 0; lutCodes = '0; spanLast = 12'd1; threshold = 8'd100;
    flagsIndex = 0; flagSel = 0; lastFlagsLo = 32'hA5A5_0F0F; lastFlagsHi = 32'h1234_8001;
    repeat (3) @(negedge clk);
    checkEq("R7 flags after reset", {curFlagsHi, curFlagsLo}, 64'h0);
    checkEq("R7 done after reset", 64'(frameDone), 64'h0);
    rstN = 1; modelOn = 1;

    // Frame A: horizontal, fixed width 4, threshold edge (101 vs 100)
    doneSeen = 0;
    runFrame(0, 16);
    checkEq("R2/R5 frame A flags", {curFlagsHi, curFlagsLo}, 64'h5);
    checkEq("R8 frame A one done pulse", 64'(doneSeen), 64'd1);
    // Pixel past the last block is ignored
    pixValid = 1; pixX = 12'd16; pixY = 12'd1; pixLuma = 8'd0; @(negedge clk);
    pixValid = 0; @(negedge clk);
    checkEq("R4 out-of-range pixel flag", 64'(pixFlagValid), 64'h0);
    checkEq("R4 out-of-range flags kept", {curFlagsHi, curFlagsLo}, 64'h5);

    // Frame B: vertical, lookup widths with index wrap, flag position wrap, live flags
    vertical = 1; widthMode = 1; lutIdx = 4'd15; blkCountM1 = 5'd2; spanLast = 12'd2;
    threshold = 8'd126; flagsIndex = 6'd62; flagSel = 1;
    for (int k = 0; k < 16; k++) lutCodes[k*6 +: 6] = 6'd5;
    lutCodes[15*6 +: 6] = 6'd0; lutCodes[0 +: 6] = 6'd2; lutCodes[6 +: 6] = 6'd1;
    doneSeen = 0;
    runFrame(1, 12);
    checkEq("R1/R3/R6 frame B flags", {curFlagsHi, curFlagsLo}, 64'h4000_0000_0000_0001);
    checkEq("R8 frame B one done pulse", 64'(doneSeen), 64'd1);

    // Frame C: statistics off, previous-frame flags drive the pixel flag
    vertical = 0; widthMode = 0; fixCode = 6'd1; blkCountM1 = 5'd3; spanLast = 12'd1;
    threshold = 8'd100; flagsIndex = 0; flagSel = 0; modeSel = 2'b10;
    doneSeen = 0;
    runFrame(0, 16);
    checkEq("R9 stats off flags", {curFlagsHi, curFlagsLo}, 64'h0);
    checkEq("R9 stats off no done", 64'(doneSeen), 64'd0);

    // Frame D: 32 blocks of width 2, flag position wraps from 40
    modeSel = 2'b11; fixCode = 6'd0; blkCountM1 = 5'd31; spanLast = 12'd0; flagsIndex = 6'd40;
    doneSeen = 0;
    runFrame(2, 64);
    expD = '0;
    for (int i = 0; i < 32; i += 2) expD[(40 + i) % 64] = 1'b1;
    checkEq("R4/R6 frame D flags", {curFlagsHi, curFlagsLo}, expD);
    checkEq("R8 frame D one done pulse", 64'(doneSeen), 64'd1);

    // Frame start colliding with a pixel
    frameStart = 1; pixValid = 1; pixX = 0; pixY = 0; pixLuma = 8'd255; @(negedge clk);
    frameStart = 0; pixValid = 0; @(negedge clk);
    checkEq("R7 clear flags", {curFlagsHi, curFlagsLo}, 64'h0);
    checkEq("R7 colliding pixel ignored", 64'(pixFlagValid), 64'h0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule